// File: doc/BRIEF.md
# Self-Timed Message Byte Sequencer

This block plays out a fixed message of thirteen ASCII bytes, one byte per clock cycle, starting by itself as soon as reset is released. It has no data inputs. It makes its own one-cycle kick-off pulse from a constant-high level and a single register. The pulse then moves through a one-hot chain of single-cycle delay stages, one stage per clock.

Each stage of the chain enables one column of a bit matrix that is built at elaboration time from a byte parameter. Within the enabled column, every 1 bit ORs onto its output row, and every 0 bit adds nothing. After the token drops out of the last stage, the block raises a sticky done flag. It then stays silent until the next reset, which re-arms it and replays the message from the first byte.

Top module: `token_msg_seq`

## Requirements
- R1: While reset is high at a clock edge, the outputs after that edge are `msg_valid`=0, `msg_done`=0 and `msg_byte`=0x00. Reset is synchronous and active high.
- R2: The first clock edge with reset low is edge 1. In the cycle after edge 1, `msg_valid`=1 and `msg_byte` carries the first message byte, 0x48 ('H') by default.
- R3: After edge k, for k = 1 to 13, `msg_valid`=1 and `msg_byte` is byte k of the message in string order. With the default parameter, the bytes are "Hello, World!", ending with 0x21. Bit 7 is zero for every default byte.
- R4: Whenever `msg_valid` is 0, `msg_byte` is 0x00.
- R5: `msg_done` is 0 until edge 13 has passed. It is 1 from edge 14 onward and stays 1 until a reset edge.
- R6: The start pulse fires once per reset. After the last byte, `msg_valid` stays 0 and the message is not repeated while reset stays low.
- R7: A reset edge in the middle of the message clears it at once. The next edge with reset low starts over from the first byte.
- R8: A reset edge that falls in the same cycle as the last byte takes priority over termination. `msg_done` does not rise, and the message restarts from the first byte after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| msg_byte | output | 8 | Current message byte, zero when not valid |
| msg_valid | output | 1 | High while a message byte is presented |
| msg_done | output | 1 | Sticky flag, set after the last byte |

## Verification
Reset and termination can land in the same cycle. The bench provokes this by raising reset exactly when the last byte is on the output. It then checks that `msg_done` stays low through the reset edge, and that the whole message replays from the first byte once reset is dropped. A mid-message reset is also exercised against the same cycle-counting reference model. That model tracks edges since release and predicts byte, valid and done on every cycle.

// File: rtl/token_msg_seq_pkg.sv
package token_msg_seq_pkg;

    localparam int unsigned CHAR_W      = 8;
    localparam int unsigned DEF_N_CHARS = 13;

    typedef logic [CHAR_W-1:0] char_t;

    // state of the kick-off pulse generator
    typedef struct packed {
        logic armed;
    } kick_state_t;

endpackage

// File: rtl/kick_pulse_gen.sv
module kick_pulse_gen (
    input  logic clk,
    input  logic rst,
    output logic kick
);
    import token_msg_seq_pkg::*;

    logic        always_hi;
    kick_state_t st_d, st_q;

    assign always_hi = 1'b1;

    always_comb begin
        st_d       = st_q;
        st_d.armed = always_hi;
        if (rst) st_d.armed = 1'b0;
        // high only while the delayed copy of the constant is still low
        kick = always_hi & ~st_q.armed & ~rst;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // one-shot: a kick is never followed by another until reset
    p_kick_once_r6: assert property (@(posedge clk) disable iff (rst)
        kick |=> !kick);

endmodule

// File: rtl/token_chain.sv
module token_chain #(
    parameter int unsigned N_STAGES = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                kick,
    output logic [N_STAGES-1:0] stage_hot,
    output logic                finished
);
    typedef struct packed {
        logic [N_STAGES-1:0] tok;
        logic                fin;
    } chain_state_t;

    chain_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // each stage takes its upstream neighbour's token
        st_d.tok[0] = kick;
        for (int s = 1; s < N_STAGES; s++) begin
            st_d.tok[s] = st_q.tok[s-1];
        end
        // token leaving the last stage terminates the sequence
        if (st_q.tok[N_STAGES-1]) st_d.fin = 1'b1;
        if (rst) begin
            st_d.tok = '0;
            st_d.fin = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stage_hot = st_q.tok;
    assign finished  = st_q.fin;

    p_single_token_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage_hot));

    p_token_steps_r3: assert property (@(posedge clk) disable iff (rst)
        (stage_hot != '0 && !stage_hot[N_STAGES-1]) |=>
            (stage_hot == ($past(stage_hot) << 1)));

    p_fin_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        stage_hot[N_STAGES-1] |=> finished);

    p_fin_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        finished |=> finished);

endmodule

// File: rtl/or_column_matrix.sv
module or_column_matrix #(
    parameter int unsigned N_COLS = 13,
    parameter int unsigned ROW_W  = 8,
    parameter logic [N_COLS*ROW_W-1:0] CONTENT = '0
) (
    input  logic [N_COLS-1:0] col_sel,
    output logic [ROW_W-1:0]  rows
);
    // column c holds string character c; character 0 sits at the top of CONTENT
    for (genvar r = 0; r < ROW_W; r++) begin : g_row
        always_comb begin
            rows[r] = 1'b0;
            for (int c = 0; c < N_COLS; c++) begin
                if (CONTENT[(N_COLS-1-c)*ROW_W + r]) begin
                    rows[r] = rows[r] | col_sel[c];
                end
            end
        end
    end

endmodule

// File: rtl/token_msg_seq.sv
module token_msg_seq #(
    parameter int unsigned N_CHARS = token_msg_seq_pkg::DEF_N_CHARS,
    parameter logic [N_CHARS*token_msg_seq_pkg::CHAR_W-1:0] MESSAGE = "Hello, World!"
) (
    input  logic       clk,
    input  logic       rst,
    output logic [7:0] msg_byte,
    output logic       msg_valid,
    output logic       msg_done
);
    import token_msg_seq_pkg::*;

    localparam int unsigned W = CHAR_W;

    logic               kick;
    logic [N_CHARS-1:0] hot;
    logic               fin;
    char_t              col_bits;

    kick_pulse_gen u_kick (
        .clk  (clk),
        .rst  (rst),
        .kick (kick)
    );

    token_chain #(.N_STAGES(N_CHARS)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick),
        .stage_hot (hot),
        .finished  (fin)
    );

    or_column_matrix #(
        .N_COLS  (N_CHARS),
        .ROW_W   (W),
        .CONTENT (MESSAGE)
    ) u_matrix (
        .col_sel (hot),
        .rows    (col_bits)
    );

    assign msg_byte  = col_bits;
    assign msg_valid = |hot;
    assign msg_done  = fin;

    p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |-> (msg_byte == '0));

    p_silent_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        msg_done |-> !msg_valid);

    p_first_byte_r2: assert property (@(posedge clk) disable iff (rst)
        kick |=> (msg_valid && msg_byte == MESSAGE[(N_CHARS-1)*W +: W]));

endmodule

// File: tb/tb_token_msg_seq.sv
module tb_token_msg_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] msg_byte;
    logic       msg_valid;
    logic       msg_done;

    int    checks = 0;
    int    errors = 0;
    int    kk = 0;          // edges with reset low since last reset edge
    int    ticks = 0;
    bit    started = 0;
    bit    finished_run = 0;
    string phase = "";
    string msg = "Hello, World!";

    always #2.5 clk = ~clk;  // 200 MHz

    token_msg_seq dut (
        .clk       (clk),
        .rst       (rst),
        .msg_byte  (msg_byte),
        .msg_valid (msg_valid),
        .msg_done  (msg_done)
    );

    // reference model: count edges since reset release
    always @(posedge clk) begin
        ticks <= ticks + 1;
        started <= 1'b1;
        if (rst) kk <= 0;
        else if (kk < 1000) kk <= kk + 1;
    end

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (ticks > 20000 && !finished_run) begin
            finished_run = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (started && !finished_run) begin
            logic       ev, ed;
            logic [7:0] eb;
            string      tag;
            ev = (kk >= 1 && kk <= 13);
            eb = ev ? 8'(msg[kk-1]) : 8'h00;
            ed = (kk >= 14);
            if (kk == 0)       tag = "R1";
            else if (kk == 1)  tag = "R2";
            else if (kk <= 13) tag = "R3";
            else               tag = "R5";

            checks++;
            if (msg_valid !== ev) begin
                errors++;
                $display("FAIL %s%s/R6 valid k=%0d: actual %b expected %b",
                         phase, tag, kk, msg_valid, ev);
            end
            checks++;
            if (msg_byte !== eb) begin
                errors++;
                $display("FAIL %s%s/R4 byte k=%0d: actual %h expected %h",
                         phase, tag, kk, msg_byte, eb);
            end
            checks++;
            if (msg_done !== ed) begin
                errors++;
                $display("FAIL %s%s done k=%0d: actual %b expected %b",
                         phase, tag, kk, msg_done, ed);
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        phase = "";
        cycles(3);
        rst = 1'b0;
        // R2, R3, R4, R5, R6: full message and silence afterwards
        cycles(25);
        // R7: reset in the middle of the message
        rst = 1'b1; phase = "R7:";
        cycles(2);
        rst = 1'b0;
        cycles(6);
        rst = 1'b1;
        cycles(1);
        rst = 1'b0;
        cycles(16);
        // R8: reset in the same cycle as the last byte
        rst = 1'b1; phase = "R8:";
        cycles(2);
        rst = 1'b0;
        while (kk != 13) @(negedge clk);
        rst = 1'b1;
        cycles(1);
        if (msg_done !== 1'b0) begin
            errors++;
            $display("FAIL R8 done after reset: actual %b expected 0", msg_done);
        end
        checks++;
        rst = 1'b0;
        cycles(20);
        finished_run = 1;
        report();
    end

endmodule